// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers eight maskable peripheral interrupt lines and one non-maskable line and turns them into a single request to a processor. The request carries the vector of the chosen source. Each maskable source has its own 3-bit priority, a mask bit and a trigger type, either edge or level. Software sets these, together with a vector base, a global enable and a mode bit, through a simple register write port.

The processor side works like a valid/ready pair. `cpu_req` acts as valid and `cpu_vec` as its data, while `cpu_ack` acts as ready. A service is taken only in a cycle where both are high. While `cpu_ack` stays low the controller keeps re-evaluating, so `cpu_vec` may move to a newly arrived, more urgent source before the hand-off. Holding `cpu_ack` low costs nothing: pending sources simply wait.

On each hand-off, the level of the chosen source is pushed onto a four-entry in-service stack. An end-of-interrupt pulse pops that stack. In sequential mode, nothing new is offered while any routine is in service. In nested mode, only a source whose level is strictly above the top of the stack is offered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_req` is low and the in-service stack is empty. Every maskable source is masked with priority 0 and level trigger. The global enable is off, the mode is sequential and the vector base is 0x20.
- R2: A write takes effect on the clock edge where `cfg_we` is high. Addresses 0..7 each hold one source's setting: bits 2:0 are the priority (7 is highest), bit 3 is the mask (1 = masked) and bit 4 is the trigger type (1 = edge, 0 = level). Address 8 holds the vector base. At address 9, bit 0 is the global enable and bit 1 selects nested mode (1) or sequential mode (0).
- R3: Among eligible maskable sources, the one with the highest priority is offered. A tie goes to the lower index. `cpu_vec` equals the base plus the source index, and equals the base plus 8 for the non-maskable source.
- R4: A masked source, or any maskable source while the global enable is off, is never offered. Its edge latch still records rising edges.
- R5: An edge-triggered source becomes pending on a rising edge of its input. It stays pending after the input falls, until that source is acknowledged.
- R6: A level-triggered source is pending exactly while its input is high.
- R7: The non-maskable line is edge-triggered and has level 8, above every maskable source. It is offered whatever the global enable and the mask bits are set to, and its latch clears when it is acknowledged.
- R8: A hand-off takes place only in a cycle where `cpu_req` and `cpu_ack` are both high. It pushes the chosen level and clears the chosen edge latch. `cpu_ack` while `cpu_req` is low has no effect.
- R9: In sequential mode, `cpu_req` stays low while the stack is not empty.
- R10: In nested mode, a source is offered only if its level is strictly greater than the top of the stack. Equal or lower levels wait.
- R11: `cpu_eoi` pops one entry off the stack. An `cpu_eoi` pulse while the stack is empty is ignored.
- R12: While all four stack entries are in use, `cpu_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| src_irq | input | 8 | Maskable interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| cpu_ack | input | 1 | Processor accepts the offered vector (ready) |
| cpu_eoi | input | 1 | End of the current service routine |
| cpu_req | output | 1 | Request to the processor (valid) |
| cpu_vec | output | 8 | Vector of the offered source |

## Verification
A wrong stack depth shows up at the ports in the very next cycle, as a request that appears or stays missing against the mode rules: a request during service in sequential mode, a missing preemption in nested mode, or a request while the stack is full. A stale or lost edge latch appears as a wrong or missing vector only after the next end-of-interrupt, or only once a higher-level routine has finished. Because of that delay, the checks replay full nest-and-unwind sequences and compare each vector at the hand-off.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1 << PRIO_W);

  typedef struct packed {
    logic              edge_trig;
    logic              masked;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/pic_src_pending.sv
module pic_src_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q, latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= line_in;
      latch_q <= (latch_q & ~clr) | (edge_mode & line_in & ~prev_q);
    end
  end

  assign pend = edge_mode ? latch_q : line_in;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]             elig,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                         nmi_pend,
  output logic                         win_valid,
  output logic [IDX_W-1:0]             win_idx,
  output logic [LVL_W-1:0]             win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!win_valid || {1'b0, prio[i]} >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = {1'b0, prio[i]};
      end
    end
    if (nmi_pend) begin
      win_valid = 1'b1;
      win_idx   = IDX_W'(N_SRC);
      win_lvl   = NMI_LVL;
    end
  end
endmodule

// File: rtl/pic_isr_stack.sv
module pic_isr_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [DW-1:0]    depth,
  output logic [LVL_W-1:0] top_lvl,
  output logic             empty,
  output logic             full
);
  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [DW-1:0]    depth_q;
  logic [DW-1:0]    dm1;

  assign dm1   = depth_q - 1'b1;
  assign empty = (depth_q == '0);
  assign full  = (int'(depth_q) == DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push && pop && !empty) begin
      mem_q[dm1[AW-1:0]] <= push_lvl;
    end else if (push && !full) begin
      mem_q[depth_q[AW-1:0]] <= push_lvl;
      depth_q <= depth_q + 1'b1;
    end else if (pop && !empty) begin
      depth_q <= dm1;
    end
  end

  assign depth   = depth_q;
  assign top_lvl = empty ? '0 : mem_q[dm1[AW-1:0]];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DEPTH = 4,
  parameter int VEC_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [VEC_W-1:0] BASE_RST = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              nmi_in,
  input  logic              cpu_ack,
  input  logic              cpu_eoi,
  output logic              cpu_req,
  output logic [VEC_W-1:0]  cpu_vec
);
  localparam int IDX_W = $clog2(N_SRC + 1);
  localparam int DW    = $clog2(DEPTH + 1);
  localparam int A_BASE = N_SRC;
  localparam int A_CTRL = N_SRC + 1;

  src_cfg_t                    cfg_q [N_SRC];
  logic [VEC_W-1:0]            base_q;
  logic                        glob_en_q, nested_q;
  logic [N_SRC-1:0]            pend, elig;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_v;
  logic                        nmi_pend, take, stk_empty, stk_full;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl, top_lvl;
  logic                        win_valid;
  logic [DW-1:0]               stk_depth;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) cfg_q[i] <= '{edge_trig: 1'b0, masked: 1'b1, prio: '0};
      base_q    <= BASE_RST;
      glob_en_q <= 1'b0;
      nested_q  <= 1'b0;
    end else if (cfg_we) begin
      if (int'(cfg_addr) < N_SRC) cfg_q[cfg_addr] <= src_cfg_t'(cfg_wdata[PRIO_W+1:0]);
      else if (int'(cfg_addr) == A_BASE) base_q <= VEC_W'(cfg_wdata);
      else if (int'(cfg_addr) == A_CTRL) begin
        glob_en_q <= cfg_wdata[0];
        nested_q  <= cfg_wdata[1];
      end
    end
  end

  assign take = cpu_req && cpu_ack;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    pic_src_pending u_pend (
      .clk(clk), .rst_n(rst_n), .line_in(src_irq[g]),
      .edge_mode(cfg_q[g].edge_trig),
      .clr(take && (win_idx == IDX_W'(g))),
      .pend(pend[g])
    );
    assign elig[g]   = pend[g] && !cfg_q[g].masked && glob_en_q;
    assign prio_v[g] = cfg_q[g].prio;
  end

  pic_src_pending u_nmi (
    .clk(clk), .rst_n(rst_n), .line_in(nmi_in), .edge_mode(1'b1),
    .clr(take && (win_idx == IDX_W'(N_SRC))), .pend(nmi_pend)
  );

  pic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .elig(elig), .prio(prio_v), .nmi_pend(nmi_pend),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  pic_isr_stack #(.DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(cpu_eoi),
    .push_lvl(win_lvl), .depth(stk_depth), .top_lvl(top_lvl),
    .empty(stk_empty), .full(stk_full)
  );

  assign cpu_req = win_valid && !stk_full &&
                   (stk_empty || (nested_q && (win_lvl > top_lvl)));
  assign cpu_vec = base_q + VEC_W'(win_idx);
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N_SRC = 8,
  parameter int DEPTH = 4,
  parameter int VEC_W = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_ack,
  input logic             cpu_eoi,
  input logic [VEC_W-1:0] cpu_vec,
  input logic [VEC_W-1:0] vec_base,
  input logic             nested,
  input logic [DW-1:0]    depth
);
  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nested && depth != '0) |-> !cpu_req);
  // R12
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(depth) == DEPTH) |-> !cpu_req);
  // R8
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ack && !cpu_eoi) |=> depth == $past(depth) + 1'b1);
  // R11
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && depth != '0 && !(cpu_req && cpu_ack)) |=> depth == $past(depth) - 1'b1);
  // R11
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && depth == '0 && !cpu_req) |=> depth == '0);
  // R3
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> VEC_W'(cpu_vec - vec_base) <= VEC_W'(N_SRC));
endmodule

bind prio_irq_ctrl pic_chk #(.N_SRC(N_SRC), .DEPTH(DEPTH), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
  .cpu_eoi(cpu_eoi), .cpu_vec(cpu_vec), .vec_base(base_q),
  .nested(nested_q), .depth(stk_depth)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] src_irq = '0;
  logic       nmi_in = 1'b0, cpu_ack = 1'b0, cpu_eoi = 1'b0;
  logic       cpu_req;
  logic [7:0] cpu_vec;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] exp_q [$];
  bit         done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_irq(src_irq), .nmi_in(nmi_in),
    .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .cpu_req(cpu_req), .cpu_vec(cpu_vec)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: every hand-off is compared against the scoreboard queue (R8, R3)
  always @(negedge clk) begin
    if (rst_n && cpu_req && cpu_ack) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8 unexpected hand-off: actual vec %02h expected none", cpu_vec);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (cpu_vec !== e) begin
          n_bad++;
          $display("FAIL R8 hand-off vector: actual %02h expected %02h", cpu_vec, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic pulse(input logic [7:0] m, input logic nmi);
    @(posedge clk); #1; src_irq = src_irq | m; nmi_in = nmi;
    @(posedge clk); #1; src_irq = src_irq & ~m; nmi_in = 0;
  endtask

  task automatic serve(input logic [7:0] v);
    @(posedge clk); #1; exp_q.push_back(v); cpu_ack = 1;
    @(posedge clk); #1; cpu_ack = 0;
  endtask

  task automatic eoi();
    @(posedge clk); #1; cpu_eoi = 1;
    @(posedge clk); #1; cpu_eoi = 0;
  endtask

  task automatic expect_req(input string tag, input logic r, input logic [7:0] v);
    @(negedge clk);
    n_chk++;
    if (cpu_req !== r || (r && cpu_vec !== v)) begin
      n_bad++;
      $display("FAIL %s: actual req=%b vec=%02h expected req=%b vec=%02h", tag, cpu_req, cpu_vec, r, v);
    end
  endtask

  initial begin
    repeat (400) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    expect_req("R1 reset idle", 0, 8'h00);
    // R2 configuration
    wr(4'd8, 8'h40);
    wr(4'd0, 8'h02);               // level, prio 2
    wr(4'd1, 8'h15);               // edge, prio 5
    wr(4'd2, 8'h15);
    wr(4'd3, 8'h0F);               // masked, prio 7
    src_irq[3] = 1; src_irq[0] = 1; tick(1);
    expect_req("R4 global enable off", 0, 8'h00);
    wr(4'd9, 8'h01);
    expect_req("R4 masked prio 7 loses, R2 base", 1, 8'h40);
    pulse(8'h02, 0); tick(1);
    expect_req("R5 edge latched after fall, R3 higher prio", 1, 8'h41);
    serve(8'h41);
    expect_req("R9 sequential hold", 0, 8'h00);
    eoi();
    expect_req("R11 pop then level src", 1, 8'h40);
    pulse(8'h06, 0); tick(1);
    expect_req("R3 tie to lower index", 1, 8'h41);
    serve(8'h41); eoi();
    expect_req("R8 edge cleared only for chosen", 1, 8'h42);
    serve(8'h42); eoi();
    expect_req("R5 both edges consumed", 1, 8'h40);
    @(posedge clk); #1; src_irq[0] = 0;
    expect_req("R6 level drop", 0, 8'h00);
    @(posedge clk); #1; cpu_ack = 1; @(posedge clk); #1; cpu_ack = 0;
    src_irq[0] = 1;
    expect_req("R8 ack without req ignored", 1, 8'h40);
    // nested mode
    wr(4'd9, 8'h03);
    serve(8'h40);
    expect_req("R10 equal level waits", 0, 8'h00);
    pulse(8'h02, 0);
    expect_req("R10 higher preempts", 1, 8'h41);
    serve(8'h41);
    pulse(8'h04, 0);
    expect_req("R10 equal edge waits", 0, 8'h00);
    pulse(8'h00, 1);
    expect_req("R7 nmi outranks", 1, 8'h48);
    serve(8'h48);
    eoi();
    expect_req("R10 equal after pop", 0, 8'h00);
    eoi();
    expect_req("R11 pop reveals lower top", 1, 8'h42);
    serve(8'h42); eoi(); eoi();
    expect_req("R11 unwound to empty", 1, 8'h40);
    eoi(); tick(1);
    expect_req("R11 eoi on empty ignored", 1, 8'h40);
    wr(4'd9, 8'h02);
    expect_req("R4 enable off in nested", 0, 8'h00);
    pulse(8'h00, 1);
    expect_req("R7 nmi bypasses enable", 1, 8'h48);
    serve(8'h48); eoi();
    expect_req("R7 nmi latch cleared", 0, 8'h00);
    // stack depth
    wr(4'd9, 8'h03);
    serve(8'h40);
    pulse(8'h02, 0); serve(8'h41);
    wr(4'd4, 8'h06); src_irq[4] = 1; tick(1);
    expect_req("R10 prio 6 over 5", 1, 8'h44);
    serve(8'h44);
    wr(4'd3, 8'h07);
    expect_req("R2 unmask prio 7", 1, 8'h43);
    serve(8'h43);
    pulse(8'h00, 1);
    expect_req("R12 full stack blocks nmi", 0, 8'h00);
    eoi();
    expect_req("R12 room again, R7 nmi", 1, 8'h48);
    tick(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R8 missing hand-offs: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule